// File: doc/BRIEF.md
# Multi-cycle shared-bus 8-bit processor

This block is a small processor that runs one instruction over several clock cycles. Every transfer uses one 8-bit bus, and that bus has one driver in each cycle. The driver is the data input, one of eight general registers, or the result register. An operand register holds the first arithmetic operand. A two-bit step counter drives a decoder that produces the load enables and the bus select for each step.

The instruction word and the immediate data both arrive on `din_i`. When the block is idle, it loads an instruction word only while `run_i` is high. A move or an immediate move takes two cycles. An add or a subtract takes four. The block raises `done_o` for one cycle in the last step of each instruction. It can accept the next instruction word in the following cycle. The bus is visible on `bus_o`, so a register move of a register onto itself reads that register back without changing it.

Top module: `busproc`

## Requirements
- R1: The reset `rst_ni` is asynchronous and active low. It clears the step counter, the instruction register, the operand and result registers, and all eight general registers. After reset, `done_o` is 0 and the block is idle. An instruction that is interrupted by reset leaves no result.
- R2: While the block is idle and `run_i` is 0, the step counter stays at T0. The word on `din_i` is ignored, `done_o` stays 0 and no register changes.
- R3: The instruction word is split into three fields. Bits [7:6] hold the opcode, bits [5:3] hold the destination index x, and bits [2:0] hold the source index y. The opcodes are 00 for a move, 01 for an immediate move, 10 for add and 11 for subtract.
- R4: A move loads Rx from Ry. In T1, Ry drives the bus, Rx is written and `done_o` is 1. This is two cycles counted from the T0 that loads the word. Ry is not changed, unless it is the same register as Rx.
- R5: An immediate move takes the immediate from `din_i` in T1. That value drives the bus, Rx is loaded and `done_o` is 1 in the same cycle.
- R6: An add takes four cycles. In T1, Rx drives the bus and loads register A. In T2, Ry drives the bus and register B loads A+Ry. In T3, B drives the bus, Rx is written and `done_o` is 1.
- R7: A subtract uses the same four steps as an add, but B loads A−Ry. All arithmetic wraps modulo 256, and any carry or borrow is dropped.
- R8: `done_o` stays high for exactly one cycle, and the step counter returns to T0 after it. An instruction word presented in the next cycle is accepted, with no idle cycle between the two instructions.
- R9: An arithmetic instruction with x equal to y uses the old value of Rx for both operands. For example, add R5,R5 doubles R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all registers capture on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Lets the block load an instruction word while it is idle |
| din_i | input | 8 | Instruction word in T0, immediate data in T1 of an immediate move |
| done_o | output | 1 | One-cycle pulse in the final step of an instruction |
| bus_o | output | 8 | Current value of the shared bus |

## Verification
A wrong step count shows at once as `done_o` rising in the wrong cycle, and every instruction checks its latency, so the error appears within the same instruction. A bad register write or a wrong adder result does not show at once. It appears on the bus in the done cycle of the instruction that wrote the value. If a later instruction reads that register, the error shows again on the bus, at the latest in T1 or T2 of that instruction. The bench therefore checks the bus in every step of the arithmetic instructions. It also ends each test phase with self-moves that read the register file back. This way a stale or corrupted register is caught within a few instructions.

// File: rtl/busproc_pkg.sv
package busproc_pkg;
  typedef enum logic [1:0] {
    OP_MOV  = 2'b00,
    OP_MOVI = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SRC_DIN = 2'd0,
    SRC_GPR = 2'd1,
    SRC_RES = 2'd2
  } bus_src_e;
endpackage

// File: rtl/busproc_regfile.sv
module busproc_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && wr_idx_i == SEL_W'(g))    regs_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];

  // R4: a write lands in the addressed register
  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/busproc_alu.sv
module busproc_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] y_o
);
  // modulo 2^DATA_W, carry dropped
  assign y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/busproc_ctrl.sv
module busproc_ctrl
  import busproc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] din_i,
  output bus_src_e          src_o,
  output logic [SEL_W-1:0]  rd_idx_o,
  output logic              gpr_we_o,
  output logic [SEL_W-1:0]  wr_idx_o,
  output logic              a_en_o,
  output logic              b_en_o,
  output logic              sub_o,
  output logic              done_o
);
  logic [1:0]        step_q, step_d;
  logic [DATA_W-1:0] ir_q;
  logic              ir_en;
  op_e               op;
  logic [SEL_W-1:0]  rx, ry;

  assign op = op_e'(ir_q[DATA_W-1 -: 2]);
  assign rx = ir_q[2*SEL_W-1 -: SEL_W];
  assign ry = ir_q[SEL_W-1:0];

  always_comb begin
    src_o    = SRC_DIN;
    rd_idx_o = ry;
    gpr_we_o = 1'b0;
    wr_idx_o = rx;
    a_en_o   = 1'b0;
    b_en_o   = 1'b0;
    sub_o    = 1'b0;
    done_o   = 1'b0;
    ir_en    = 1'b0;
    unique case (step_q)
      2'd0: ir_en = run_i;
      2'd1: begin
        unique case (op)
          OP_MOV:  begin src_o = SRC_GPR; gpr_we_o = 1'b1; done_o = 1'b1; end
          OP_MOVI: begin src_o = SRC_DIN; gpr_we_o = 1'b1; done_o = 1'b1; end
          default: begin src_o = SRC_GPR; rd_idx_o = rx; a_en_o = 1'b1; end
        endcase
      end
      2'd2: begin
        src_o  = SRC_GPR;
        b_en_o = 1'b1;
        sub_o  = (op == OP_SUB);
      end
      default: begin src_o = SRC_RES; gpr_we_o = 1'b1; done_o = 1'b1; end
    endcase
  end

  always_comb begin
    if (done_o)                    step_d = 2'd0;
    else if (step_q != 2'd0 || run_i) step_d = step_q + 2'd1;
    else                           step_d = step_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 2'd0;
      ir_q   <= '0;
    end else begin
      step_q <= step_d;
      if (ir_en) ir_q <= din_i;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_back_to_t0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> step_q == 2'd0);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == 2'd0 && !run_i) |=> step_q == 2'd0);
  p_move_short_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == 2'd1 && !ir_q[DATA_W-1]) |-> done_o);
  p_arith_long_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == 2'd2) |=> (step_q == 2'd3 && done_o));
  p_sub_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_en_o |-> (sub_o == (op == OP_SUB)));
endmodule

// File: rtl/busproc.sv
module busproc
  import busproc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              done_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam int SEL_W = $clog2(NREG);

  bus_src_e          src;
  logic [SEL_W-1:0]  rd_idx, wr_idx;
  logic              gpr_we, a_en, b_en, sub;
  logic [DATA_W-1:0] gpr_rd, alu_y, a_q, b_q, bus;

  busproc_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_ctrl (
    .clk_i, .rst_ni, .run_i, .din_i,
    .src_o(src), .rd_idx_o(rd_idx), .gpr_we_o(gpr_we), .wr_idx_o(wr_idx),
    .a_en_o(a_en), .b_en_o(b_en), .sub_o(sub), .done_o(done_o)
  );

  busproc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_data_o(gpr_rd),
    .we_i(gpr_we), .wr_idx_i(wr_idx), .wr_data_i(bus)
  );

  busproc_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i(a_q), .b_i(bus), .sub_i(sub), .y_o(alu_y)
  );

  always_comb begin
    unique case (src)
      SRC_GPR: bus = gpr_rd;
      SRC_RES: bus = b_q;
      default: bus = din_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= bus;
      if (b_en) b_q <= alu_y;
    end
  end

  assign bus_o = bus;

  // R6: A samples the bus; B holds the staged result when it is driven
  p_a_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_en |=> a_q == $past(bus));
  p_b_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_en |=> (src == SRC_RES && bus == $past(sub ? a_q - bus : a_q + bus)));
endmodule

// File: tb/busproc_bench.sv
module busproc_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [7:0] din_i = 8'h00;
  logic       done_o;
  logic [7:0] bus_o;

  busproc u_busproc (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] model [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: every done cycle must match the oldest expected result
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(bus_o == e.val, e.req, "bus in done cycle", bus_o, e.val);
      end
    end
  end

  // driver: op R3 encoding {op[1:0], x[2:0], y[2:0]}
  task automatic exec(input logic [1:0] op, input int rx, input int ry,
                      input logic [7:0] imm, input string req);
    logic [7:0] res;
    int         lat;
    int         cyc;
    bit         got;
    exp_t       e;
    unique case (op)
      2'b00: res = model[ry];
      2'b01: res = imm;
      2'b10: res = model[rx] + model[ry];
      default: res = model[rx] - model[ry];
    endcase
    lat = op[1] ? 3 : 1;
    e.val = res; e.req = req;
    sb_q.push_back(e);
    @(negedge clk_i);
    din_i = {op, rx[2:0], ry[2:0]};
    run_i = 1'b1;
    cyc = 0; got = 0;
    while (!got && cyc < 8) begin
      @(negedge clk_i);
      run_i = 1'b0;
      din_i = imm;
      cyc++;
      #2;
      if (op[1] && cyc == 1) chk(bus_o == model[rx], "R6", "T1 bus = Rx", bus_o, model[rx]);
      if (op[1] && cyc == 2) chk(bus_o == model[ry], "R6", "T2 bus = Ry", bus_o, model[ry]);
      if (done_o) got = 1;
    end
    chk(cyc == lat, req, "done step", cyc, lat);
    model[rx] = res;
  endtask

  task automatic readback(input string req);
    for (int i = 0; i < 8; i++) exec(2'b00, i, i, 8'h00, req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    din_i = 8'h5A;
    #1;
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    chk(bus_o == 8'h5A, "R1", "idle bus shows din", bus_o, 8'h5A);
    readback("R1");

    // R5 immediates, R4 moves
    for (int i = 0; i < 8; i++) exec(2'b01, i, 0, 8'h11 * i + 8'h03, "R5");
    exec(2'b00, 2, 7, 8'h00, "R4");
    exec(2'b00, 6, 1, 8'h00, "R4");
    readback("R4");

    // worked sequence, back to back (R8)
    exec(2'b01, 5, 0, 8'hB8, "R5");
    exec(2'b00, 6, 5, 8'h00, "R4");
    exec(2'b01, 5, 0, 8'h6F, "R5");
    exec(2'b10, 6, 5, 8'h00, "R6");
    exec(2'b10, 5, 5, 8'h00, "R9");
    exec(2'b11, 5, 6, 8'h00, "R7");
    chk(model[5] == 8'hB7, "R7", "model R5", model[5], 8'hB7);
    chk(model[6] == 8'h27, "R6", "model R6", model[6], 8'h27);

    // wrap cases
    exec(2'b01, 0, 0, 8'h00, "R5");
    exec(2'b01, 1, 0, 8'h01, "R5");
    exec(2'b11, 0, 1, 8'h00, "R7");
    exec(2'b01, 3, 0, 8'hFF, "R5");
    exec(2'b10, 3, 1, 8'h00, "R6");
    exec(2'b11, 4, 4, 8'h00, "R9");
    exec(2'b10, 7, 7, 8'h00, "R9");
    readback("R8");

    // R2: run low ignores din
    @(negedge clk_i);
    run_i = 1'b0;
    din_i = {2'b01, 3'd2, 3'd0};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      #2;
      chk(done_o == 1'b0, "R2", "done while run low", done_o, 0);
    end
    readback("R2");

    // R1: reset in the middle of an add
    @(negedge clk_i);
    din_i = {2'b10, 3'd1, 3'd2};
    run_i = 1'b1;
    @(negedge clk_i);
    run_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    @(negedge clk_i);
    #2;
    chk(done_o == 1'b0, "R1", "done during reset", done_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      #2;
      chk(done_o == 1'b0, "R1", "aborted op finishes", done_o, 0);
    end
    readback("R1");
    exec(2'b01, 4, 0, 8'hC3, "R5");
    exec(2'b10, 4, 4, 8'h00, "R9");
    readback("R9");

    repeat (2) @(negedge clk_i);
    chk(sb_q.size() == 0, "R8", "pending results", sb_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule